// File: doc/BRIEF.md
# Debug Exception Fault-Record Unit

This block holds the abort-recording state of a small processor core and updates it when a debug exception is taken. It keeps five word-wide registers: data fault status, instruction fault status, data fault address, instruction fault address, and a separate watchpoint fault address. Which of them change depends on the cause of the event. Watchpoints touch the data side and the watchpoint address. Breakpoint-class events touch the instruction side. Plain prefetch and data aborts leave all five untouched.

The core presents each event as a one-cycle valid pulse. The pulse carries a 3-bit cause code, the address of the instruction involved, an instruction-state flag (0 for 32-bit encoding, 1 for 16-bit encoding), a monitor-debug-mode flag and a vector-catch target kind. On the following clock edge the block raises a one-cycle exception-taken strobe and presents the link-register value for the handler. A vector catch on an abort vector is dropped while monitor mode is active, so the handler can never re-enter itself. Software can load any of the five registers through a simple write port.

Top module: `dbg_fault_rec`

## Requirements
- R1: A synchronous active-low reset clears all five registers, the link output and the taken strobe to zero.
- R2: On a watchpoint (cause code 1), the data fault status register gets the debug-event code 5'b00010 zero-extended and the data fault address register gets zero; both instruction-side registers keep their values.
- R3: On a watchpoint, the watchpoint fault address register gets the event address plus 8 when the state flag is 0, or plus 4 when it is 1, wrapping modulo 2^32.
- R4: On a breakpoint (code 0), a software breakpoint instruction (code 2) or a taken vector catch (code 3), the instruction fault status register gets 5'b00010 zero-extended and the instruction fault address register gets zero; the data fault status, data fault address and watchpoint address registers keep their values.
- R5: A vector catch whose target kind is 1 (prefetch-abort vector) or 2 (data-abort vector) is ignored while the monitor flag is 1. No strobe is raised and no register or link value changes. Kinds 0 and 3, or a monitor flag of 0, let the catch be taken.
- R6: The link output becomes the event address plus 4 for codes 0, 2, 3 and 4, and plus 8 for codes 1 and 5, in either instruction state. It changes only on a taken event.
- R7: The taken strobe is high for exactly the one cycle after a taken event. Reserved cause codes 6 and 7 are ignored like a suppressed vector catch.
- R8: A prefetch abort (code 4) or data abort (code 5) raises the strobe and updates the link value but changes none of the five registers.
- R9: With the write enable high, write-select 0 to 4 loads the data into data fault status, instruction fault status, data fault address, instruction fault address or watchpoint address respectively on the next edge. Selects 5 to 7 change nothing.
- R10: When an event and a software write land in the same cycle, the event's value wins in each register that the event updates. A register that the event leaves alone takes the software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_vld | input | 1 | One-cycle event pulse |
| evt_cause | input | 3 | Cause code (0 breakpoint, 1 watchpoint, 2 software breakpoint, 3 vector catch, 4 prefetch abort, 5 data abort) |
| evt_addr | input | 32 | Address of the instruction involved |
| evt_isa16 | input | 1 | Instruction state: 1 for 16-bit encoding |
| mon_mode | input | 1 | Monitor debug mode active |
| vc_kind | input | 2 | Vector-catch target (1 prefetch-abort vector, 2 data-abort vector, else other) |
| wr_en | input | 1 | Software write enable |
| wr_sel | input | 3 | Software write register select |
| wr_data | input | 32 | Software write data |
| dstat_o | output | 32 | Data fault status |
| istat_o | output | 32 | Instruction fault status |
| daddr_o | output | 32 | Data fault address |
| iaddr_o | output | 32 | Instruction fault address |
| waddr_o | output | 32 | Watchpoint fault address |
| link_o | output | 32 | Link-register value for the taken exception |
| taken_o | output | 1 | Exception-taken strobe |

## Verification
Each event is preceded by loading all five registers with distinct sentinel values. A cause that wrote the wrong side, or that failed to keep a side it must not touch, therefore shows up as a changed or unchanged sentinel. The bench sends vector catches to each target kind with the monitor flag both set and clear. A design that suppressed too widely or too narrowly would raise or drop the strobe and corrupt the instruction side. Watchpoints in both instruction states and at an address that wraps past the top expose a swapped or truncated offset. A same-cycle collision between an event and a software write catches a priority that blocks the whole write or lets software win.

// File: rtl/dbg_fr_pkg.sv
// Package: shared constants and codes for the debug fault-record unit.
// Assumes a single word width for all recorded registers.
package dbg_fr_pkg;
    localparam int NREG = 5;

    // Cause codes carried with each event pulse.
    typedef enum logic [2:0] {
        CZ_BRK  = 3'd0,
        CZ_WPT  = 3'd1,
        CZ_SWBK = 3'd2,
        CZ_VCAT = 3'd3,
        CZ_PABT = 3'd4,
        CZ_DABT = 3'd5
    } cause_e;

    // Register slots, also the software write-select values.
    localparam int SL_DSTAT = 0;
    localparam int SL_ISTAT = 1;
    localparam int SL_DADDR = 2;
    localparam int SL_IADDR = 3;
    localparam int SL_WADDR = 4;

    // Vector-catch target kinds.
    localparam logic [1:0] VK_PABT = 2'd1;
    localparam logic [1:0] VK_DABT = 2'd2;

    // Status code written on a debug event.
    localparam logic [4:0] DBG_EVT_CODE = 5'b00010;

    // Offsets.
    localparam int WP_OFF_WIDE   = 8;
    localparam int WP_OFF_NARROW = 4;
    localparam int LNK_SHORT     = 4;
    localparam int LNK_LONG      = 8;
endpackage

// File: rtl/dbg_fr_decode.sv
// Module: dbg_fr_decode
// Purely combinational. Turns an event (cause, state, mode, vector kind)
// into a taken flag, a per-register update mask with update values, and
// the link value. Undefined address fields are written as zero.
// Assumes DW >= 5.
module dbg_fr_decode
    import dbg_fr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                      evt_vld,
    input  logic [2:0]                evt_cause,
    input  logic [DW-1:0]             evt_addr,
    input  logic                      evt_isa16,
    input  logic                      mon_mode,
    input  logic [1:0]                vc_kind,
    output logic                      taken,
    output logic [NREG-1:0]           upd,
    output logic [NREG-1:0][DW-1:0]   upd_val,
    output logic [DW-1:0]             link_val
);
    localparam logic [DW-1:0] EVT_WORD = {{(DW-5){1'b0}}, DBG_EVT_CODE};

    logic          vc_masked;
    logic [DW-1:0] lnk_off;
    logic [DW-1:0] wp_off;

    // Abort-vector catches are dropped in monitor mode.
    always_comb vc_masked = mon_mode && (vc_kind == VK_PABT || vc_kind == VK_DABT);

    // Watchpoint address offset depends on instruction state.
    always_comb wp_off = evt_isa16 ? DW'(WP_OFF_NARROW) : DW'(WP_OFF_WIDE);

    // Cause decode: which registers change and to what.
    always_comb begin
        taken   = 1'b0;
        upd     = '0;
        upd_val = '0;
        lnk_off = DW'(LNK_SHORT);
        if (evt_vld) begin
            case (evt_cause)
                CZ_WPT: begin
                    taken             = 1'b1;
                    lnk_off           = DW'(LNK_LONG);
                    upd[SL_DSTAT]     = 1'b1;
                    upd_val[SL_DSTAT] = EVT_WORD;
                    upd[SL_DADDR]     = 1'b1;
                    upd[SL_WADDR]     = 1'b1;
                    upd_val[SL_WADDR] = evt_addr + wp_off;
                end
                CZ_BRK, CZ_SWBK, CZ_VCAT: begin
                    if (!(evt_cause == CZ_VCAT && vc_masked)) begin
                        taken             = 1'b1;
                        upd[SL_ISTAT]     = 1'b1;
                        upd_val[SL_ISTAT] = EVT_WORD;
                        upd[SL_IADDR]     = 1'b1;
                    end
                end
                CZ_PABT: taken = 1'b1;
                CZ_DABT: begin
                    taken   = 1'b1;
                    lnk_off = DW'(LNK_LONG);
                end
                default: taken = 1'b0;
            endcase
        end
    end

    // Link value for the handler.
    always_comb link_val = evt_addr + lnk_off;
endmodule

// File: rtl/dbg_fr_bank.sv
// Module: dbg_fr_bank
// The five recorded registers. Each register takes its event update
// first and a matching software write otherwise. Assumes upd/upd_val are
// combinational from the same cycle's event.
module dbg_fr_bank
    import dbg_fr_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0]           upd,
    input  logic [NREG-1:0][DW-1:0]   upd_val,
    input  logic                      wr_en,
    input  logic [SW-1:0]             wr_sel,
    input  logic [DW-1:0]             wr_data,
    output logic [NREG-1:0][DW-1:0]   q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic sw_hit;

        // Software write decode for this slot.
        always_comb sw_hit = wr_en && (wr_sel == SW'(g));

        // Register update: reset, then event, then software.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[g] <= '0;
            else if (upd[g]) q[g] <= upd_val[g];
            else if (sw_hit) q[g] <= wr_data;
        end

        assert_sw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_hit && !upd[g]) |=> (q[g] == $past(wr_data)));

        assert_evt_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            upd[g] |=> (q[g] == $past(upd_val[g])));

        assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd[g] && !sw_hit) |=> $stable(q[g]));
    end
endmodule

// File: rtl/dbg_fr_link.sv
// Module: dbg_fr_link
// Registers the taken strobe and the link value. The link value holds
// between taken events.
module dbg_fr_link #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          taken,
    input  logic [DW-1:0] link_val,
    output logic          taken_q,
    output logic [DW-1:0] link_q
);
    // Strobe and link capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            link_q  <= '0;
        end else begin
            taken_q <= taken;
            if (taken) link_q <= link_val;
        end
    end

    assert_link_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> $stable(link_q));
endmodule

// File: rtl/dbg_fault_rec.sv
// Module: dbg_fault_rec (top)
// Debug exception fault-record unit: decodes a one-cycle event pulse,
// updates the fault-record registers, and produces the link value and a
// taken strobe one edge later. Assumes events are single-cycle pulses.
module dbg_fault_rec
    import dbg_fr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_vld,
    input  logic [2:0]    evt_cause,
    input  logic [DW-1:0] evt_addr,
    input  logic          evt_isa16,
    input  logic          mon_mode,
    input  logic [1:0]    vc_kind,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] dstat_o,
    output logic [DW-1:0] istat_o,
    output logic [DW-1:0] daddr_o,
    output logic [DW-1:0] iaddr_o,
    output logic [DW-1:0] waddr_o,
    output logic [DW-1:0] link_o,
    output logic          taken_o
);
    logic                    taken;
    logic [NREG-1:0]         upd;
    logic [NREG-1:0][DW-1:0] upd_val;
    logic [DW-1:0]           link_val;
    logic [NREG-1:0][DW-1:0] regs;

    dbg_fr_decode #(.DW(DW)) u_dec (
        .evt_vld   (evt_vld),
        .evt_cause (evt_cause),
        .evt_addr  (evt_addr),
        .evt_isa16 (evt_isa16),
        .mon_mode  (mon_mode),
        .vc_kind   (vc_kind),
        .taken     (taken),
        .upd       (upd),
        .upd_val   (upd_val),
        .link_val  (link_val)
    );

    dbg_fr_bank #(.DW(DW), .SW(3)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .upd_val (upd_val),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .q       (regs)
    );

    dbg_fr_link #(.DW(DW)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .taken    (taken),
        .link_val (link_val),
        .taken_q  (taken_o),
        .link_q   (link_o)
    );

    // Output mapping of the register slots.
    always_comb begin
        dstat_o = regs[SL_DSTAT];
        istat_o = regs[SL_ISTAT];
        daddr_o = regs[SL_DADDR];
        iaddr_o = regs[SL_IADDR];
        waddr_o = regs[SL_WADDR];
    end

    assert_wp_iside_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_cause == CZ_WPT && !wr_en)
        |=> ($stable(istat_o) && $stable(iaddr_o)));

    assert_wp_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_cause == CZ_WPT)
        |=> (waddr_o == $past(evt_addr) + ($past(evt_isa16) ? DW'(4) : DW'(8))));

    assert_bp_dside_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && (evt_cause == CZ_BRK || evt_cause == CZ_SWBK) && !wr_en)
        |=> ($stable(dstat_o) && $stable(daddr_o) && $stable(waddr_o)));

    assert_vc_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_cause == CZ_VCAT && mon_mode &&
         (vc_kind == VK_PABT || vc_kind == VK_DABT)) |=> !taken_o);

    assert_dabt_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_cause == CZ_DABT) |=> (link_o == $past(evt_addr) + DW'(8)));

    assert_strobe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(evt_vld));

    assert_abort_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && (evt_cause == CZ_PABT || evt_cause == CZ_DABT) && !wr_en)
        |=> ($stable(dstat_o) && $stable(istat_o) && $stable(waddr_o)));
endmodule

// File: tb/dbg_fault_rec_tb.sv
// Bench for dbg_fault_rec: vector table walk plus directed tests.
module dbg_fault_rec_tb_top;
    localparam int DW = 32;

    typedef struct packed {
        logic [2:0]  cause;
        logic        isa16;
        logic        mon;
        logic [1:0]  vck;
        logic [31:0] addr;
        logic        taken;
        logic [31:0] link;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 2'd0, 32'h0000_1000, 1'b1, 32'h0000_1004},
        '{3'd1, 1'b0, 1'b0, 2'd0, 32'h0000_2000, 1'b1, 32'h0000_2008},
        '{3'd1, 1'b1, 1'b0, 2'd0, 32'h0000_3002, 1'b1, 32'h0000_300A},
        '{3'd2, 1'b1, 1'b0, 2'd0, 32'h0000_4000, 1'b1, 32'h0000_4004},
        '{3'd3, 1'b0, 1'b0, 2'd1, 32'h0000_0018, 1'b1, 32'h0000_001C},
        '{3'd3, 1'b0, 1'b1, 2'd1, 32'h0000_000C, 1'b0, 32'h0000_0000},
        '{3'd3, 1'b1, 1'b1, 2'd2, 32'h0000_0010, 1'b0, 32'h0000_0000},
        '{3'd3, 1'b0, 1'b1, 2'd0, 32'h0000_0008, 1'b1, 32'h0000_000C},
        '{3'd4, 1'b0, 1'b0, 2'd0, 32'h0000_5000, 1'b1, 32'h0000_5004},
        '{3'd5, 1'b1, 1'b0, 2'd0, 32'h0000_6000, 1'b1, 32'h0000_6008},
        '{3'd6, 1'b0, 1'b0, 2'd0, 32'h0000_7000, 1'b0, 32'h0000_0000},
        '{3'd7, 1'b0, 1'b0, 2'd0, 32'h0000_7100, 1'b0, 32'h0000_0000},
        '{3'd1, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFFC, 1'b1, 32'h0000_0004},
        '{3'd3, 1'b0, 1'b1, 2'd3, 32'h0000_0020, 1'b1, 32'h0000_0024}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_vld = 1'b0;
    logic [2:0]    evt_cause = '0;
    logic [DW-1:0] evt_addr = '0;
    logic          evt_isa16 = 1'b0;
    logic          mon_mode = 1'b0;
    logic [1:0]    vc_kind = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] dstat_o, istat_o, daddr_o, iaddr_o, waddr_o, link_o;
    logic          taken_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [31:0] exp_r [5];
    logic [31:0] exp_link;

    always #10 clk = ~clk;

    dbg_fault_rec #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_cause(evt_cause),
        .evt_addr(evt_addr), .evt_isa16(evt_isa16), .mon_mode(mon_mode),
        .vc_kind(vc_kind), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dstat_o(dstat_o), .istat_o(istat_o), .daddr_o(daddr_o),
        .iaddr_o(iaddr_o), .waddr_o(waddr_o), .link_o(link_o), .taken_o(taken_o)
    );

    function automatic logic [31:0] get_reg(int s);
        case (s)
            0: return dstat_o;
            1: return istat_o;
            2: return daddr_o;
            3: return iaddr_o;
            default: return waddr_o;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_regs(string req);
        for (int s = 0; s < 5; s++) chk(req, $sformatf("reg%0d", s), get_reg(s), exp_r[s]);
    endtask

    // Load every register with a distinct sentinel.
    task automatic preload();
        for (int s = 0; s < 5; s++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 3'(s); wr_data = 32'hC0DE_0000 | 32'(s * 17 + 1);
            exp_r[s] = wr_data;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected register effect of an event, from the requirements.
    task automatic model(logic [2:0] c, logic isa, logic mon, logic [1:0] vk, logic [31:0] a);
        logic masked;
        masked = mon && (vk == 2'd1 || vk == 2'd2);
        if (c == 3'd1) begin
            exp_r[0] = 32'h2; exp_r[2] = 32'h0; exp_r[4] = a + (isa ? 32'd4 : 32'd8);
        end else if (c == 3'd0 || c == 3'd2 || (c == 3'd3 && !masked)) begin
            exp_r[1] = 32'h2; exp_r[3] = 32'h0;
        end
    endtask

    task automatic fire(logic [2:0] c, logic isa, logic mon, logic [1:0] vk, logic [31:0] a);
        @(negedge clk);
        evt_vld = 1'b1; evt_cause = c; evt_isa16 = isa; mon_mode = mon; vc_kind = vk; evt_addr = a;
        @(negedge clk);
        evt_vld = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int s = 0; s < 5; s++) exp_r[s] = '0;
        chk_regs("R1");
        chk("R1", "link", link_o, 32'h0);
        chk("R1", "taken", 32'(taken_o), 32'h0);
        rst_n = 1'b1;
        exp_link = '0;

        // Vector table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            preload();
            model(VECS[i].cause, VECS[i].isa16, VECS[i].mon, VECS[i].vck, VECS[i].addr);
            if (VECS[i].taken) exp_link = VECS[i].link;
            fire(VECS[i].cause, VECS[i].isa16, VECS[i].mon, VECS[i].vck, VECS[i].addr);
            chk("R2/R3/R4/R5/R8", $sformatf("vec%0d taken", i), 32'(taken_o), 32'(VECS[i].taken));
            chk("R6", $sformatf("vec%0d link", i), link_o, exp_link);
            chk_regs("R2/R3/R4/R5/R8");
            @(negedge clk);
            chk("R7", $sformatf("vec%0d strobe drop", i), 32'(taken_o), 32'h0);
        end

        // R9: selects 5..7 change nothing
        preload();
        for (int s = 5; s < 8; s++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 3'(s); wr_data = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk_regs("R9");

        // R10: collision, event wins on its registers, software on others
        preload();
        @(negedge clk);
        evt_vld = 1'b1; evt_cause = 3'd1; evt_isa16 = 1'b0; mon_mode = 1'b0; vc_kind = '0;
        evt_addr = 32'h0000_8000;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h1234_5678;
        @(negedge clk);
        evt_vld = 1'b0; wr_en = 1'b0;
        chk("R10", "dstat event wins", dstat_o, 32'h2);
        chk("R10", "waddr", waddr_o, 32'h0000_8008);
        preload();
        @(negedge clk);
        evt_vld = 1'b1; evt_cause = 3'd1; evt_addr = 32'h0000_9000;
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0BAD_F00D;
        @(negedge clk);
        evt_vld = 1'b0; wr_en = 1'b0;
        chk("R10", "istat software passes", istat_o, 32'h0BAD_F00D);
        chk("R10", "dstat", dstat_o, 32'h2);

        // R1: mid-run reset clears loaded state
        preload();
        @(negedge clk);
        evt_vld = 1'b1; evt_cause = 3'd0; evt_addr = 32'h0000_A000;
        @(negedge clk);
        evt_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 5; s++) exp_r[s] = '0;
        chk_regs("R1");
        chk("R1", "link after reset", link_o, 32'h0);
        chk("R1", "taken after reset", 32'(taken_o), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule